// File: doc/BRIEF.md
# Interrupt vector ring writer

This block gathers interrupt events from on-chip sources and turns each one into a fixed 128-bit vector. It stores the vectors in order in a circular buffer in host memory. Host software reads the buffer through its own read pointer. The write pointer counts in bytes and moves forward by 16 for every vector. The host controls the block through a small register write port. Through that port it sets the ring base, the ring size as log2 of 32-bit words, the enables, the overflow policy, the read pointer and the address that receives the write-pointer copy.

A four-state sequencer drives a single-beat memory write port.
- In `S_IDLE` it accepts an event when the ring is live and has room, or when overflow is allowed, and moves to `S_VEC`.
- `S_VEC` holds the vector write until the memory accepts it. At that point the write pointer advances (the commit). The sequencer then goes to `S_WB_LOAD` when writeback is on, or back to `S_IDLE` when it is off.
- `S_WB_LOAD` captures the reported write pointer and moves to `S_WB`.
- `S_WB` holds a 4-byte copy of that pointer until the memory accepts it, then returns to `S_IDLE`.

A one-cycle interrupt pulse marks each commit that takes the ring from empty to non-empty. A host read-pointer update that leaves vectors unread also raises the pulse when re-arm is on.

Top module: `ivr_writer`

## Requirements
- R1: After reset, `in_ready`, `mem_wvalid`, `irq` and `busy` are low and `wptr_rep` is zero.
- R2: The vector is written with `mem_wfull`=1 to ring base + write pointer. Its layout is:
  - source id at bits [7:0]
  - 28-bit data at [59:32]
  - ring id at [71:64]
  - VM id at [79:72]
  - 16-bit address-space id at [95:80]
  - zero at [31:8], [63:60] and [127:96].
- R3: Each commit adds 16 to the byte write pointer, modulo the ring size of 4<<n bytes. Here n is register 0 bits [5:1], clamped to the range 3..MAX_LOG2. `wptr_rep` carries the pointer with the overflow flag in bit 0.
- R4: `in_ready` is high only when both ring enable (register 0 bit 0) and interrupt enable (register 1 bit 0) are set.
- R5: With overflow disabled (register 0 bit 16 = 0), a full ring holds `in_ready` low and writes nothing. Full means (wptr+16) mod size equals rptr.
- R6: With overflow enabled, a commit into a full ring still happens and sets a sticky flag in `wptr_rep` bit 0. A write of register 0 with bit 31 set clears the flag.
- R7: With writeback enabled (register 0 bit 8), every vector is followed by one write with `mem_wfull`=0. Its data is `wptr_rep` in bits [31:0] and its address is {register 6 [7:0], register 5}.
- R8: `irq` pulses for one cycle after a commit made while wptr equals rptr. A commit made while they differ gives no pulse.
- R9: With re-arm set (register 1 bit 4), a read-pointer write (register 4) whose value differs from wptr raises `irq` for one cycle. Without re-arm, a read-pointer write gives no pulse.
- R10: A write of register 0 with bit 0 clear disables the ring. It clears interrupt enable, both pointers and the overflow flag.
- R11: `busy` is high from acceptance until the last memory write completes. While `mem_wready` is low, `mem_wvalid`, `mem_waddr` and `mem_wdata` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0 ring control, 1 interrupt control, 2/3 base low/high, 4 read pointer, 5/6 writeback low/high) |
| reg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Event offered |
| in_ready | output | 1 | Event accepted when high with in_valid |
| in_src | input | 8 | Source id |
| in_data | input | 28 | Source data |
| in_ring | input | 8 | Ring id |
| in_vm | input | 8 | VM id |
| in_pasid | input | 16 | Address-space id |
| mem_wvalid | output | 1 | Memory write request |
| mem_wready | input | 1 | Memory accepts the write |
| mem_waddr | output | 40 | Byte address |
| mem_wdata | output | 128 | Write data |
| mem_wfull | output | 1 | 1: 16-byte vector, 0: 4-byte pointer copy |
| irq | output | 1 | Interrupt pulse |
| busy | output | 1 | A memory write is pending |
| wptr_rep | output | 32 | Write pointer with overflow flag in bit 0 |

## Verification
Several rules are checked by assertions on every cycle:
- `in_ready` never rises without both enables.
- `in_ready` never rises into a full ring when overflow is off.
- A stalled write keeps its address and data.
- The overflow flag stays set until it is cleared.
- A disable zeroes the reported pointer.
- Every interrupt pulse has a cause.

The bench covers what only sequences can show: the exact vector layout and addresses as the pointer wraps over several ring sizes, including a clamped size field. It also covers the point where stalling or overwriting begins, the writeback contents, and the re-arm pulse.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
    localparam int AW       = 40;
    localparam int VW       = 128;
    localparam int SZ_W     = 5;
    localparam int MIN_LOG2 = 3;

    localparam logic [2:0] RA_RING    = 3'd0;
    localparam logic [2:0] RA_INT     = 3'd1;
    localparam logic [2:0] RA_BASE_LO = 3'd2;
    localparam logic [2:0] RA_BASE_HI = 3'd3;
    localparam logic [2:0] RA_RPTR    = 3'd4;
    localparam logic [2:0] RA_WB_LO   = 3'd5;
    localparam logic [2:0] RA_WB_HI   = 3'd6;

    localparam int RING_EN_BIT = 0;
    localparam int SZ_LSB      = 1;
    localparam int WB_EN_BIT   = 8;
    localparam int OVF_EN_BIT  = 16;
    localparam int OVF_CLR_BIT = 31;
    localparam int INT_EN_BIT  = 0;
    localparam int REARM_BIT   = 4;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_VEC     = 2'd1,
        S_WB_LOAD = 2'd2,
        S_WB      = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic [7:0]  src;
        logic [27:0] data;
        logic [7:0]  ring;
        logic [7:0]  vm;
        logic [15:0] pasid;
    } ivr_event_t;

    function automatic logic [VW-1:0] pack_vector(input ivr_event_t e);
        return {32'd0, e.pasid, e.vm, e.ring, 4'd0, e.data, 24'd0, e.src};
    endfunction
endpackage

// File: rtl/ivr_regs.sv
module ivr_regs
    import ivr_pkg::*;
#(
    parameter int MAX_LOG2 = 8,
    localparam int PTR_W = MAX_LOG2 + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic              ring_en,
    output logic              int_en,
    output logic              wb_en,
    output logic              ovf_en,
    output logic              rearm_en,
    output logic              ovf_clr,
    output logic              ring_clear,
    output logic [PTR_W-1:0]  ptr_mask,
    output logic [AW-1:0]     base_addr,
    output logic [AW-1:0]     wb_addr,
    output logic              rptr_we,
    output logic [PTR_W-1:0]  rptr_wdata
);
    logic [SZ_W-1:0] sz_q;
    logic [SZ_W-1:0] sz_eff;
    logic            ring_wr;
    logic            unused_wdata;

    assign unused_wdata = ^reg_wdata;
    assign ring_wr    = reg_wen && (reg_addr == RA_RING);
    assign ring_clear = ring_wr && !reg_wdata[RING_EN_BIT];
    assign ovf_clr    = ring_wr && reg_wdata[OVF_CLR_BIT];
    assign rptr_we    = reg_wen && (reg_addr == RA_RPTR);
    assign rptr_wdata = {reg_wdata[PTR_W-1:4], 4'd0};

    always_comb begin
        if (sz_q < SZ_W'(MIN_LOG2)) begin
            sz_eff = SZ_W'(MIN_LOG2);
        end else if (sz_q > SZ_W'(MAX_LOG2)) begin
            sz_eff = SZ_W'(MAX_LOG2);
        end else begin
            sz_eff = sz_q;
        end
    end

    assign ptr_mask = {PTR_W{1'b1}} >> (SZ_W'(MAX_LOG2) - sz_eff);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_en   <= 1'b0;
            int_en    <= 1'b0;
            wb_en     <= 1'b0;
            ovf_en    <= 1'b0;
            rearm_en  <= 1'b0;
            sz_q      <= SZ_W'(MIN_LOG2);
            base_addr <= '0;
            wb_addr   <= '0;
        end else if (reg_wen) begin
            unique case (reg_addr)
                RA_RING: begin
                    ring_en <= reg_wdata[RING_EN_BIT];
                    sz_q    <= reg_wdata[SZ_LSB +: SZ_W];
                    wb_en   <= reg_wdata[WB_EN_BIT];
                    ovf_en  <= reg_wdata[OVF_EN_BIT];
                    if (!reg_wdata[RING_EN_BIT]) begin
                        int_en <= 1'b0;
                    end
                end
                RA_INT: begin
                    int_en   <= reg_wdata[INT_EN_BIT];
                    rearm_en <= reg_wdata[REARM_BIT];
                end
                RA_BASE_LO: base_addr[31:0]  <= reg_wdata;
                RA_BASE_HI: base_addr[39:32] <= reg_wdata[7:0];
                RA_WB_LO:   wb_addr[31:0]    <= reg_wdata;
                RA_WB_HI:   wb_addr[39:32]   <= reg_wdata[7:0];
                default: ;
            endcase
        end
    end

    // R10: a disabling write drops both enables
    p_clear_enables_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ring_clear |=> (!ring_en && !int_en));
endmodule

// File: rtl/ivr_ptr.sv
module ivr_ptr #(
    parameter int PTR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [PTR_W-1:0] mask,
    input  logic             commit,
    input  logic             ovf_en,
    input  logic             ovf_clr,
    input  logic             rptr_we,
    input  logic [PTR_W-1:0] rptr_wdata,
    input  logic             rearm_en,
    input  logic             live,
    output logic [PTR_W-1:0] wptr,
    output logic [PTR_W-1:0] rptr,
    output logic             ovf_flag,
    output logic             full,
    output logic             irq
);
    logic [PTR_W-1:0] wptr_inc;
    logic [PTR_W-1:0] rptr_new;
    logic             ring_idle;
    logic             rearm_hit;

    assign wptr_inc  = (wptr + PTR_W'(16)) & mask;
    assign rptr_new  = rptr_wdata & mask;
    assign full      = (wptr_inc == rptr);
    assign ring_idle = (wptr == rptr);
    assign rearm_hit = rptr_we && rearm_en && live && (rptr_new != wptr);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wptr     <= '0;
            rptr     <= '0;
            ovf_flag <= 1'b0;
            irq      <= 1'b0;
        end else begin
            if (commit) begin
                wptr <= wptr_inc;
            end
            if (rptr_we) begin
                rptr <= rptr_new;
            end
            if (commit && full && ovf_en) begin
                ovf_flag <= 1'b1;
            end else if (ovf_clr) begin
                ovf_flag <= 1'b0;
            end
            irq <= (commit && ring_idle) || rearm_hit;
        end
    end

    // R6: the overflow flag holds until cleared or disabled
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr && !clear) |=> ovf_flag);

    // R8: every pulse has a commit or a pointer write behind it
    p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(commit || rptr_we));
endmodule

// File: rtl/ivr_seq.sv
module ivr_seq
    import ivr_pkg::*;
#(
    parameter int PTR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  ivr_event_t       evt,
    input  logic             live,
    input  logic             ring_en,
    input  logic             wb_en,
    input  logic             ovf_en,
    input  logic             full,
    input  logic [AW-1:0]    base_addr,
    input  logic [AW-1:0]    wb_addr,
    input  logic [PTR_W-1:0] wptr,
    input  logic [31:0]      wptr_rep,
    input  logic             mem_wready,
    output logic             in_ready,
    output logic             mem_wvalid,
    output logic [AW-1:0]    mem_waddr,
    output logic [VW-1:0]    mem_wdata,
    output logic             mem_wfull,
    output logic             commit,
    output logic             busy
);
    seq_state_t state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [VW-1:0] data_q;
    logic          wfull_q;
    logic          accept;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (accept) state_d = S_VEC;
            S_VEC:     if (mem_wready) state_d = (ring_en && wb_en) ? S_WB_LOAD : S_IDLE;
            S_WB_LOAD: state_d = S_WB;
            S_WB:      if (mem_wready) state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    always_comb begin
        in_ready   = (state_q == S_IDLE) && live && (!full || ovf_en);
        accept     = in_ready && in_valid;
        mem_wvalid = (state_q == S_VEC) || (state_q == S_WB);
        commit     = (state_q == S_VEC) && mem_wready && ring_en;
        busy       = (state_q != S_IDLE);
        mem_waddr  = addr_q;
        mem_wdata  = data_q;
        mem_wfull  = wfull_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            data_q  <= '0;
            wfull_q <= 1'b0;
        end else if (accept) begin
            addr_q  <= base_addr + AW'(wptr);
            data_q  <= pack_vector(evt);
            wfull_q <= 1'b1;
        end else if (state_q == S_WB_LOAD) begin
            addr_q  <= wb_addr;
            data_q  <= {96'd0, wptr_rep};
            wfull_q <= 1'b0;
        end
    end

    // R11: a stalled write keeps its request, address and data
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wvalid && !mem_wready) |=> (mem_wvalid && $stable(mem_waddr) && $stable(mem_wdata)));
endmodule

// File: rtl/ivr_writer.sv
module ivr_writer
    import ivr_pkg::*;
#(
    parameter int MAX_LOG2 = 8,
    localparam int PTR_W = MAX_LOG2 + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wen,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [7:0]    in_src,
    input  logic [27:0]   in_data,
    input  logic [7:0]    in_ring,
    input  logic [7:0]    in_vm,
    input  logic [15:0]   in_pasid,
    output logic          mem_wvalid,
    input  logic          mem_wready,
    output logic [39:0]   mem_waddr,
    output logic [127:0]  mem_wdata,
    output logic          mem_wfull,
    output logic          irq,
    output logic          busy,
    output logic [31:0]   wptr_rep
);
    logic             ring_en, int_en, wb_en, ovf_en, rearm_en;
    logic             ovf_clr, ring_clear, rptr_we, commit, full, ovf_flag, live;
    logic [PTR_W-1:0] ptr_mask, rptr_wdata, wptr, rptr;
    logic [AW-1:0]    base_addr, wb_addr;
    ivr_event_t       evt;

    assign live     = ring_en && int_en;
    assign evt      = '{src: in_src, data: in_data, ring: in_ring, vm: in_vm, pasid: in_pasid};
    assign wptr_rep = 32'(wptr) | {31'd0, ovf_flag};

    ivr_regs #(.MAX_LOG2(MAX_LOG2)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .ring_en(ring_en), .int_en(int_en), .wb_en(wb_en),
        .ovf_en(ovf_en), .rearm_en(rearm_en), .ovf_clr(ovf_clr),
        .ring_clear(ring_clear), .ptr_mask(ptr_mask), .base_addr(base_addr),
        .wb_addr(wb_addr), .rptr_we(rptr_we), .rptr_wdata(rptr_wdata)
    );

    ivr_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .clear(ring_clear), .mask(ptr_mask),
        .commit(commit), .ovf_en(ovf_en), .ovf_clr(ovf_clr), .rptr_we(rptr_we),
        .rptr_wdata(rptr_wdata), .rearm_en(rearm_en), .live(live), .wptr(wptr),
        .rptr(rptr), .ovf_flag(ovf_flag), .full(full), .irq(irq)
    );

    ivr_seq #(.PTR_W(PTR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .evt(evt), .live(live),
        .ring_en(ring_en), .wb_en(wb_en), .ovf_en(ovf_en), .full(full),
        .base_addr(base_addr), .wb_addr(wb_addr), .wptr(wptr), .wptr_rep(wptr_rep),
        .mem_wready(mem_wready), .in_ready(in_ready), .mem_wvalid(mem_wvalid),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_wfull(mem_wfull),
        .commit(commit), .busy(busy)
    );

    // R4: no acceptance unless ring and interrupts are both enabled
    p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (ring_en && int_en));

    // R5: without overflow permission a full ring never accepts
    p_no_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !ovf_en) |-> !full);

    // R10: disabling zeroes the reported pointer
    p_disable_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ring_clear |=> (wptr_rep == 32'd0));

    // R11: a pending memory write implies busy
    p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wvalid |-> busy);
endmodule

// File: tb/test_ivr_writer.sv
module test_ivr_writer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wen = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [7:0] in_src = '0;
    logic [27:0] in_data = '0;
    logic [7:0] in_ring = '0;
    logic [7:0] in_vm = '0;
    logic [15:0] in_pasid = '0;
    logic mem_wvalid;
    logic mem_wready = 1'b1;
    logic [39:0] mem_waddr;
    logic [127:0] mem_wdata;
    logic mem_wfull;
    logic irq, busy;
    logic [31:0] wptr_rep;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    bit done = 1'b0;

    int w = 0, r = 0, mask = 31;
    bit ovf = 0, ren = 0, ien = 0, wben = 0, oven = 0;
    logic [39:0] base = 40'h12_3456_7800;
    logic [39:0] wba  = 40'hAB_0000_1040;

    always #5 clk = ~clk;

    ivr_writer i_ivr_writer (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .in_valid(in_valid), .in_ready(in_ready),
        .in_src(in_src), .in_data(in_data), .in_ring(in_ring), .in_vm(in_vm),
        .in_pasid(in_pasid), .mem_wvalid(mem_wvalid), .mem_wready(mem_wready),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_wfull(mem_wfull),
        .irq(irq), .busy(busy), .wptr_rep(wptr_rep)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rep();
        return 32'(w) | {31'd0, ovf};
    endfunction

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic send(input int k, input bit stall);
        logic [127:0] vec;
        bit exp_rdy, was_full, was_idle;
        @(negedge clk);
        in_src = 8'(k * 37 + 5);
        in_data = 28'(32'h0ABCDEF0 ^ (k * 32'h0111_1111));
        in_ring = 8'(k + 1);
        in_vm = 8'(k * 3);
        in_pasid = 16'(k * 257 + 16'h0F00);
        in_valid = 1'b1;
        vec = '0;
        vec[7:0] = in_src; vec[59:32] = in_data; vec[71:64] = in_ring;
        vec[79:72] = in_vm; vec[95:80] = in_pasid;
        was_full = (((w + 16) & mask) == r);
        exp_rdy = ren && ien && (!was_full || oven);
        check("R4 R5 ready", 128'(in_ready), 128'(exp_rdy));
        if (!exp_rdy) begin
            @(negedge clk);
            check("R5 stalled ready", 128'(in_ready), 128'd0);
            check("R5 no write", 128'(mem_wvalid), 128'd0);
            in_valid = 1'b0;
            return;
        end
        if (stall) mem_wready = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 valid", 128'(mem_wvalid), 128'd1);
        check("R2 full beat", 128'(mem_wfull), 128'd1);
        check("R2 address", 128'(mem_waddr), 128'(base + 40'(w)));
        check("R2 vector", mem_wdata, vec);
        check("R11 busy", 128'(busy), 128'd1);
        if (stall) begin
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                check("R11 hold valid", 128'(mem_wvalid), 128'd1);
                check("R11 hold addr", 128'(mem_waddr), 128'(base + 40'(w)));
                check("R11 hold data", mem_wdata, vec);
            end
            mem_wready = 1'b1;
        end
        was_idle = (w == r);
        if (was_full && oven) ovf = 1'b1;
        w = (w + 16) & mask;
        @(negedge clk);
        check("R8 irq on commit", 128'(irq), 128'(was_idle));
        check("R3 R6 wptr", 128'(wptr_rep), 128'(rep()));
        if (wben) begin
            check("R7 load gap", 128'(mem_wvalid), 128'd0);
            @(negedge clk);
            check("R7 wb valid", 128'(mem_wvalid), 128'd1);
            check("R7 wb size", 128'(mem_wfull), 128'd0);
            check("R7 wb addr", 128'(mem_waddr), 128'(wba));
            check("R7 wb data", mem_wdata, 128'(rep()));
        end
        @(negedge clk);
        check("R8 single pulse", 128'(irq), 128'd0);
        check("R11 idle busy", 128'(busy), 128'd0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            nfail++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int szl[4] = '{1, 3, 4, 5};
        repeat (3) @(negedge clk);
        check("R1 ready", 128'(in_ready), 128'd0);
        check("R1 wvalid", 128'(mem_wvalid), 128'd0);
        check("R1 irq", 128'(irq), 128'd0);
        check("R1 busy", 128'(busy), 128'd0);
        check("R1 wptr", 128'(wptr_rep), 128'd0);
        rst_n = 1'b1;
        reg_wr(3'd2, base[31:0]);
        reg_wr(3'd3, 32'(base[39:32]));
        reg_wr(3'd5, wba[31:0]);
        reg_wr(3'd6, 32'(wba[39:32]));

        for (int si = 0; si < 4; si++) begin
            for (int ov = 0; ov < 2; ov++) begin
                int eff, ents;
                logic [31:0] word;
                reg_wr(3'd0, 32'd0);
                w = 0; r = 0; ovf = 0; ren = 0; ien = 0;
                check("R10 pointer zero", 128'(wptr_rep), 128'd0);
                check("R10 ready low", 128'(in_ready), 128'd0);
                eff = (szl[si] < 3) ? 3 : szl[si];
                mask = (4 << eff) - 1;
                ents = (4 << eff) / 16;
                wben = (szl[si] != 4);
                oven = ov[0];
                word = 32'd1 | (32'(szl[si]) << 1) | (32'(wben) << 8) | (32'(oven) << 16);
                reg_wr(3'd0, word);
                ren = 1;
                check("R4 int disabled", 128'(in_ready), 128'd0);
                reg_wr(3'd1, 32'd1);
                ien = 1;
                for (int k = 0; k < ents + 2; k++) send(k, k == 1);
                if (oven) begin
                    check("R6 flag set", 128'(wptr_rep[0]), 128'd1);
                    reg_wr(3'd0, word | 32'h8000_0000);
                    ovf = 0;
                    check("R6 flag cleared", 128'(wptr_rep), 128'(rep()));
                end
                reg_wr(3'd4, 32'(w));
                r = w;
                check("R9 no rearm pulse", 128'(irq), 128'd0);
                send(99, 1'b0);
            end
        end

        reg_wr(3'd0, 32'd0);
        w = 0; r = 0; ovf = 0;
        mask = 31; wben = 0; oven = 0;
        reg_wr(3'd0, 32'd1 | (32'd3 << 1));
        reg_wr(3'd1, 32'd1 | 32'd16);
        send(7, 1'b0);
        reg_wr(3'd4, 32'd0);
        check("R9 rearm pulse", 128'(irq), 128'd1);
        reg_wr(3'd4, 32'd16);
        r = 16;
        check("R9 caught up no pulse", 128'(irq), 128'd0);
        reg_wr(3'd1, 32'd0);
        ien = 0;
        check("R4 int off", 128'(in_ready), 128'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end
endmodule